// File: doc/BRIEF.md
# Fence Slot Allocator

This block hands out a small pool of fence slots to object identifiers. It keeps four things for each slot: whether the slot is owned, which object owns it, a pin count, and an age rank that gives the slot's place in a least-recently-used order. A host issues one command at a time. The commands are get, put, pin, unpin and restore-all. Each command gets a response with a status code and a slot number. Commands that change what a slot must hold also emit a programming request, which tells a downstream writer to load or clear that slot.

On a get, the block first looks for an unowned slot, starting at a programmable first-usable index. If every slot is owned, it takes the oldest slot that is not pinned and reports the object that lost it. If every slot is pinned, the get fails. The failure code depends on whether display flips are still pending. Restore-all steps through every slot, one per cycle, and re-issues its contents. This is used after a reset or a resume.

Top module: `fence_slot_alloc`

## Requirements
- R1: After reset no slot is owned, `ready` is 1, and `rsp_valid`, `evict_valid` and `prog_valid` are 0.
- R2: A get (op 1) with `cmd_tiled`=1 from an object that owns no slot takes the lowest-numbered unowned slot at or above `first_slot`. The response is status OK (0) with `rsp_fence`=1 and the slot number. A programming request with `prog_enable`=1, the slot and the object appears on the same cycle.
- R3: If that search finds no free slot, the block takes the unpinned slot at or above `first_slot` that was used least recently. `evict_valid` then reports the previous owner in `evict_obj`. A slot with a nonzero pin count is never taken.
- R4: If no slot can be taken, the get returns status EAGAIN (1) when `flip_pending` is 1 and EDEADLK (2) when it is 0. `rsp_fence`=0, no programming request is made, and no slot changes.
- R5: A get with `cmd_dirty`=0 from the object that owns a slot returns OK with that slot and makes no programming request. The slot becomes the most recently used.
- R6: A get with `cmd_dirty`=1 from an owning object reprograms the slot. If `cmd_tiled`=1, the request has enable 1 and the slot becomes most recently used. If `cmd_tiled`=0, the request has enable 0, the slot is freed and leaves the LRU order, and `rsp_fence`=0.
- R7: A get with `cmd_tiled`=0 from an object that owns no slot returns OK with `rsp_fence`=0 and changes nothing.
- R8: A put (op 2) on an owned slot whose pin count is nonzero returns EBUSY (3) and leaves the slot as it was. A put on an unpinned owned slot frees the slot and issues a request with enable 0. A put from an object that owns no slot returns OK and does nothing.
- R9: A pin (op 3) adds one to the owner's pin count and reports `rsp_fence`=1. An object with no slot gets OK with `rsp_fence`=0. A pin at the maximum count returns RANGE (4) and leaves the count unchanged.
- R10: An unpin (op 4) subtracts one from the owner's pin count. An unpin at count zero returns RANGE (4) and leaves the count unchanged. An unpin from an object with no slot returns OK with `rsp_fence`=0.
- R11: A restore-all (op 5) holds `ready` low for NSLOT cycles. During those cycles it issues one request per slot in ascending order: enable 1 with the owner for an owned slot, enable 0 for an unowned one. Each owned slot becomes most recently used as it is visited. One OK response follows the last slot.
- R12: Every other command responds one cycle after it is accepted. A command presented while `ready` is 0, and op codes 0, 6 and 7, produce no response and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 1 get, 2 put, 3 pin, 4 unpin, 5 restore-all |
| cmd_obj | input | OBJ_W | Object identifier |
| cmd_tiled | input | 1 | Object wants a fence |
| cmd_dirty | input | 1 | Object's tiling parameters changed |
| first_slot | input | SW | Lowest slot the search may use |
| flip_pending | input | 1 | Display flips still hold slots |
| ready | output | 1 | Command accepted this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | 0 OK, 1 EAGAIN, 2 EDEADLK, 3 EBUSY, 4 RANGE |
| rsp_slot | output | SW | Slot concerned |
| rsp_fence | output | 1 | Object holds a slot after the command |
| evict_valid | output | 1 | A slot was taken from an owner |
| evict_obj | output | OBJ_W | Owner that lost its slot |
| prog_valid | output | 1 | Slot programming request |
| prog_slot | output | SW | Slot to program |
| prog_enable | output | 1 | 1 load owner, 0 clear |
| prog_obj | output | OBJ_W | Object to load |

## Verification
Some internal faults stay hidden at first. A wrong age rank changes nothing until every slot is owned and a get has to take one. At that point the wrong victim shows up in `evict_obj` and `rsp_slot` one cycle later. A lost pin count shows up at the next put or unpin on that slot, as a missing EBUSY or RANGE status. A stale owner bit shows up right away, either as a free search that skips a slot or as a restore request with the wrong enable. To bring these faults out, the bench fills the pool, pins slots in a chosen order and moves the first usable index. It then compares every output on every cycle against a reference model built on a queue.

// File: rtl/fsa_pkg.sv
// Shared command and status encodings for the fence slot allocator.
package fsa_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_GET     = 3'd1,
        OP_PUT     = 3'd2,
        OP_PIN     = 3'd3,
        OP_UNPIN   = 3'd4,
        OP_RESTORE = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_EAGAIN  = 3'd1,
        ST_EDEADLK = 3'd2,
        ST_EBUSY   = 3'd3,
        ST_RANGE   = 3'd4
    } sts_e;
endpackage

// File: rtl/fsa_slot_store.sv
// Per-slot storage: ownership bit, owner identifier and pin count.
// Assumes the controller asserts at most one of own_set/own_clr and at most
// one of pin_inc/pin_dec per cycle. Claiming a slot resets its pin count.
module fsa_slot_store #(
    parameter int NSLOT = 8,
    parameter int OBJ_W = 8,
    parameter int PIN_W = 2,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OBJ_W-1:0]       look_obj,
    output logic                   look_hit,
    output logic [SW-1:0]          look_idx,
    input  logic                   own_set,
    input  logic                   own_clr,
    input  logic [SW-1:0]          own_idx,
    input  logic [OBJ_W-1:0]       own_obj,
    input  logic                   pin_inc,
    input  logic                   pin_dec,
    input  logic [SW-1:0]          pin_idx,
    output logic [NSLOT-1:0]       owned_o,
    output logic [NSLOT-1:0]       pinned_o,
    output logic [NSLOT*OBJ_W-1:0] owner_o,
    output logic [NSLOT*PIN_W-1:0] pins_o
);
    logic             own_q [NSLOT];
    logic [OBJ_W-1:0] obj_q [NSLOT];
    logic [PIN_W-1:0] pin_q [NSLOT];

    // Ownership and owner identifier update
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (!rst_n) begin
                own_q[i] <= 1'b0;
                obj_q[i] <= '0;
            end else if (own_set && own_idx == SW'(i)) begin
                own_q[i] <= 1'b1;
                obj_q[i] <= own_obj;
            end else if (own_clr && own_idx == SW'(i)) begin
                own_q[i] <= 1'b0;
            end
        end
    end

    // Pin counter update, cleared when a slot changes hands
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (!rst_n)
                pin_q[i] <= '0;
            else if (own_set && own_idx == SW'(i))
                pin_q[i] <= '0;
            else if (pin_inc && pin_idx == SW'(i))
                pin_q[i] <= pin_q[i] + 1'b1;
            else if (pin_dec && pin_idx == SW'(i))
                pin_q[i] <= pin_q[i] - 1'b1;
        end
    end

    // Owner lookup and flattening of the slot state
    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        for (int i = 0; i < NSLOT; i++) begin
            owned_o[i]                  = own_q[i];
            pinned_o[i]                 = (pin_q[i] != '0);
            owner_o[i*OBJ_W +: OBJ_W]   = obj_q[i];
            pins_o[i*PIN_W +: PIN_W]    = pin_q[i];
            if (own_q[i] && obj_q[i] == look_obj) begin
                look_hit = 1'b1;
                look_idx = SW'(i);
            end
        end
    end

    AST_PIN_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pin_dec |-> pin_q[pin_idx] != '0); // R10
    AST_PIN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pin_inc |-> pin_q[pin_idx] != '1); // R9
    AST_NO_PINNED_STEAL: assert property (@(posedge clk) disable iff (!rst_n) own_set |-> (!own_q[own_idx] || pin_q[own_idx] == '0)); // R3
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) own_set |-> !look_hit); // R2
endmodule

// File: rtl/fsa_lru_rank.sv
// Age-rank LRU order: rank 0 is most recent, ranks among listed slots stay
// dense 0..k-1. Touch moves a slot to rank 0 (inserting it if absent); drop
// removes it and closes the gap. Assumes touch and drop never coincide.
module fsa_lru_rank #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                touch_en,
    input  logic                drop_en,
    input  logic [SW-1:0]       idx,
    output logic [NSLOT*SW-1:0] rank_o
);
    logic [SW-1:0]    rank_q [NSLOT];
    logic [NSLOT-1:0] inl_q;

    // Single-cycle rank renumbering on touch or drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inl_q <= '0;
            for (int i = 0; i < NSLOT; i++) rank_q[i] <= '0;
        end else if (touch_en) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (inl_q[i] && (!inl_q[idx] || rank_q[i] < rank_q[idx]))
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
            rank_q[idx] <= '0;
            inl_q[idx]  <= 1'b1;
        end else if (drop_en && inl_q[idx]) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (inl_q[i] && rank_q[i] > rank_q[idx])
                    rank_q[i] <= rank_q[i] - 1'b1;
            end
            inl_q[idx] <= 1'b0;
        end
    end

    // Flatten ranks for the victim picker
    always_comb begin
        for (int i = 0; i < NSLOT; i++) rank_o[i*SW +: SW] = rank_q[i];
    end

    AST_ONE_LRU_OP: assert property (@(posedge clk) disable iff (!rst_n) !(touch_en && drop_en)); // R12

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        AST_RANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) inl_q[g] |-> (int'(rank_q[g]) < $countones(inl_q))); // R5
    end
endmodule

// File: rtl/fsa_slot_pick.sv
// Combinational slot choice: lowest free slot at or above first_slot, and
// the oldest (highest rank) owned unpinned slot in the same range.
module fsa_slot_pick #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]    owned,
    input  logic [NSLOT-1:0]    pinned,
    input  logic [NSLOT*SW-1:0] rank_i,
    input  logic [SW-1:0]       first_slot,
    output logic                free_hit,
    output logic [SW-1:0]       free_idx,
    output logic                vic_hit,
    output logic [SW-1:0]       vic_idx
);
    logic [SW-1:0] best;

    // Free search: a downward scan leaves the lowest match
    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (i >= int'(first_slot) && !owned[i]) begin
                free_hit = 1'b1;
                free_idx = SW'(i);
            end
        end
    end

    // Victim search: oldest unpinned owned slot in range
    always_comb begin
        vic_hit = 1'b0;
        vic_idx = '0;
        best    = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i >= int'(first_slot) && owned[i] && !pinned[i] &&
                (!vic_hit || rank_i[i*SW +: SW] > best)) begin
                vic_hit = 1'b1;
                vic_idx = SW'(i);
                best    = rank_i[i*SW +: SW];
            end
        end
    end
endmodule

// File: rtl/fence_slot_alloc.sv
// Fence slot allocator top: decodes one command per ready cycle, drives the
// slot store and LRU ranks, and registers response, eviction and slot
// programming outputs. Restore-all walks the slots one per cycle with
// ready low. Assumes first_slot and flip_pending are stable per command.
module fence_slot_alloc #(
    parameter int NSLOT = 8,
    parameter int OBJ_W = 8,
    parameter int PIN_W = 2,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [OBJ_W-1:0] cmd_obj,
    input  logic             cmd_tiled,
    input  logic             cmd_dirty,
    input  logic [SW-1:0]    first_slot,
    input  logic             flip_pending,
    output logic             ready,
    output logic             rsp_valid,
    output logic [2:0]       rsp_status,
    output logic [SW-1:0]    rsp_slot,
    output logic             rsp_fence,
    output logic             evict_valid,
    output logic [OBJ_W-1:0] evict_obj,
    output logic             prog_valid,
    output logic [SW-1:0]    prog_slot,
    output logic             prog_enable,
    output logic [OBJ_W-1:0] prog_obj
);
    import fsa_pkg::*;

    logic                   hit, free_hit, vic_hit;
    logic [SW-1:0]          hit_idx, free_idx, vic_idx, tgt;
    logic [NSLOT-1:0]       owned_w, pinned_w;
    logic [NSLOT*OBJ_W-1:0] owner_w;
    logic [NSLOT*PIN_W-1:0] pins_w;
    logic [NSLOT*SW-1:0]    rank_w;
    logic [PIN_W-1:0]       hit_pin;

    logic                   own_set, own_clr, pin_inc, pin_dec;
    logic [SW-1:0]          own_idx, lru_idx;
    logic                   lru_touch, lru_drop, start_walk;
    logic                   walking_q, walk_last;
    logic [SW-1:0]          walk_idx_q;

    logic                   nx_rsp_v, nx_fence, nx_ev_v, nx_pr_v, nx_pr_en;
    sts_e                   nx_sts;
    logic [SW-1:0]          nx_slot, nx_pr_slot;
    logic [OBJ_W-1:0]       nx_ev_obj, nx_pr_obj;

    fsa_slot_store #(.NSLOT(NSLOT), .OBJ_W(OBJ_W), .PIN_W(PIN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .look_obj(cmd_obj), .look_hit(hit),
        .look_idx(hit_idx), .own_set(own_set), .own_clr(own_clr),
        .own_idx(own_idx), .own_obj(cmd_obj), .pin_inc(pin_inc),
        .pin_dec(pin_dec), .pin_idx(hit_idx), .owned_o(owned_w),
        .pinned_o(pinned_w), .owner_o(owner_w), .pins_o(pins_w)
    );

    fsa_lru_rank #(.NSLOT(NSLOT)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(lru_touch), .drop_en(lru_drop),
        .idx(lru_idx), .rank_o(rank_w)
    );

    fsa_slot_pick #(.NSLOT(NSLOT)) u_pick (
        .owned(owned_w), .pinned(pinned_w), .rank_i(rank_w),
        .first_slot(first_slot), .free_hit(free_hit), .free_idx(free_idx),
        .vic_hit(vic_hit), .vic_idx(vic_idx)
    );

    assign ready     = !walking_q;
    assign walk_last = (walk_idx_q == SW'(NSLOT - 1));
    assign hit_pin   = pins_w[hit_idx*PIN_W +: PIN_W];
    assign tgt       = free_hit ? free_idx : vic_idx;

    // Command decode and restore-walk step selection
    always_comb begin
        nx_rsp_v = 1'b0;  nx_sts = ST_OK;  nx_slot = '0;  nx_fence = 1'b0;
        nx_ev_v = 1'b0;   nx_ev_obj = '0;
        nx_pr_v = 1'b0;   nx_pr_en = 1'b0; nx_pr_slot = '0; nx_pr_obj = '0;
        own_set = 1'b0;   own_clr = 1'b0;  own_idx = hit_idx;
        pin_inc = 1'b0;   pin_dec = 1'b0;
        lru_touch = 1'b0; lru_drop = 1'b0; lru_idx = hit_idx;
        start_walk = 1'b0;
        if (walking_q) begin
            nx_pr_v    = 1'b1;
            nx_pr_slot = walk_idx_q;
            lru_idx    = walk_idx_q;
            if (owned_w[walk_idx_q]) begin
                nx_pr_en  = 1'b1;
                nx_pr_obj = owner_w[walk_idx_q*OBJ_W +: OBJ_W];
                lru_touch = 1'b1;
            end
            nx_rsp_v = walk_last;
        end else if (cmd_valid) begin
            case (op_e'(cmd_op))
                OP_GET: begin
                    nx_rsp_v = 1'b1;
                    if (hit) begin
                        nx_slot  = hit_idx;
                        nx_fence = 1'b1;
                        if (!cmd_dirty) begin
                            lru_touch = 1'b1;
                        end else if (cmd_tiled) begin
                            lru_touch  = 1'b1;
                            nx_pr_v    = 1'b1;
                            nx_pr_en   = 1'b1;
                            nx_pr_slot = hit_idx;
                            nx_pr_obj  = cmd_obj;
                        end else begin
                            lru_drop   = 1'b1;
                            own_clr    = 1'b1;
                            nx_fence   = 1'b0;
                            nx_pr_v    = 1'b1;
                            nx_pr_slot = hit_idx;
                        end
                    end else if (cmd_tiled && (free_hit || vic_hit)) begin
                        nx_slot    = tgt;
                        nx_fence   = 1'b1;
                        own_set    = 1'b1;
                        own_idx    = tgt;
                        lru_touch  = 1'b1;
                        lru_idx    = tgt;
                        nx_pr_v    = 1'b1;
                        nx_pr_en   = 1'b1;
                        nx_pr_slot = tgt;
                        nx_pr_obj  = cmd_obj;
                        nx_ev_v    = !free_hit;
                        nx_ev_obj  = owner_w[tgt*OBJ_W +: OBJ_W];
                    end else if (cmd_tiled) begin
                        nx_sts = flip_pending ? ST_EAGAIN : ST_EDEADLK;
                    end
                end
                OP_PUT: begin
                    nx_rsp_v = 1'b1;
                    if (hit) begin
                        nx_slot = hit_idx;
                        if (hit_pin != '0) begin
                            nx_sts   = ST_EBUSY;
                            nx_fence = 1'b1;
                        end else begin
                            own_clr    = 1'b1;
                            lru_drop   = 1'b1;
                            nx_pr_v    = 1'b1;
                            nx_pr_slot = hit_idx;
                        end
                    end
                end
                OP_PIN, OP_UNPIN: begin
                    nx_rsp_v = 1'b1;
                    nx_slot  = hit_idx;
                    nx_fence = hit;
                    if (hit && cmd_op == OP_PIN) begin
                        if (hit_pin == '1) nx_sts  = ST_RANGE;
                        else               pin_inc = 1'b1;
                    end else if (hit) begin
                        if (hit_pin == '0) nx_sts  = ST_RANGE;
                        else               pin_dec = 1'b1;
                    end
                end
                OP_RESTORE: start_walk = 1'b1;
                default: ;
            endcase
        end
    end

    // Restore walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walking_q  <= 1'b0;
            walk_idx_q <= '0;
        end else if (start_walk) begin
            walking_q  <= 1'b1;
            walk_idx_q <= '0;
        end else if (walking_q) begin
            walking_q  <= !walk_last;
            walk_idx_q <= walk_idx_q + 1'b1;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_status <= '0; rsp_slot <= '0; rsp_fence <= 1'b0;
            evict_valid <= 1'b0; evict_obj <= '0;
            prog_valid <= 1'b0; prog_slot <= '0; prog_enable <= 1'b0; prog_obj <= '0;
        end else begin
            rsp_valid <= nx_rsp_v; rsp_status <= nx_sts; rsp_slot <= nx_slot; rsp_fence <= nx_fence;
            evict_valid <= nx_ev_v; evict_obj <= nx_ev_obj;
            prog_valid <= nx_pr_v; prog_slot <= nx_pr_slot; prog_enable <= nx_pr_en; prog_obj <= nx_pr_obj;
        end
    end

    AST_EVICT_ON_CLAIM: assert property (@(posedge clk) disable iff (!rst_n) evict_valid |-> (rsp_valid && rsp_status == ST_OK && prog_valid && prog_enable)); // R3
    AST_FAIL_NO_FENCE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && (rsp_status == ST_EAGAIN || rsp_status == ST_EDEADLK)) |-> (!rsp_fence && !prog_valid && !evict_valid)); // R4
    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !rsp_valid); // R11
    AST_WALK_EMITS: assert property (@(posedge clk) disable iff (!rst_n) (!ready && $past(!ready)) |-> prog_valid); // R11
endmodule

// File: tb/sim_fence_slot_alloc.sv
// Cycle reference model of the allocator (arrays and a queue for LRU order),
// updated at each rising edge and compared against every output at the
// falling edge.
module sim_fence_slot_alloc;
    localparam int NS = 8;
    localparam int OW = 8;
    localparam int PW = 2;
    localparam int SW = $clog2(NS);
    localparam int PMAX = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [OW-1:0] cmd_obj = '0;
    logic cmd_tiled = 1'b0, cmd_dirty = 1'b0, flip_pending = 1'b0;
    logic [SW-1:0] first_slot = '0;
    logic ready, rsp_valid, rsp_fence, evict_valid, prog_valid, prog_enable;
    logic [2:0] rsp_status;
    logic [SW-1:0] rsp_slot, prog_slot;
    logic [OW-1:0] evict_obj, prog_obj;

    always #4 clk = ~clk;

    fence_slot_alloc #(.NSLOT(NS), .OBJ_W(OW), .PIN_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_obj(cmd_obj), .cmd_tiled(cmd_tiled), .cmd_dirty(cmd_dirty),
        .first_slot(first_slot), .flip_pending(flip_pending), .ready(ready),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_slot(rsp_slot),
        .rsp_fence(rsp_fence), .evict_valid(evict_valid), .evict_obj(evict_obj),
        .prog_valid(prog_valid), .prog_slot(prog_slot),
        .prog_enable(prog_enable), .prog_obj(prog_obj)
    );

    int total = 0;
    int bad = 0;
    bit started = 0;

    // model state
    bit m_own [NS];
    int m_obj [NS];
    int m_pin [NS];
    int lru [$];
    int m_walk = -1;

    // expected outputs
    int e_rv, e_st, e_sl, e_fe, e_ev, e_eo, e_pv, e_pe, e_ps, e_po, e_rdy;
    string e_tag = "R1";

    function automatic int find_obj(int o);
        for (int i = 0; i < NS; i++) if (m_own[i] && m_obj[i] == o) return i;
        return -1;
    endfunction

    function automatic void lru_del(int s);
        for (int k = 0; k < lru.size(); k++) if (lru[k] == s) begin lru.delete(k); break; end
    endfunction

    function automatic void lru_touch(int s);
        lru_del(s);
        lru.push_back(s);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model step
    always @(posedge clk) begin
        int h, f, v, fs;
        started = 1;
        e_rv = 0; e_ev = 0; e_pv = 0; e_st = 0; e_fe = 0; e_sl = 0;
        e_pe = 0; e_ps = 0; e_po = 0; e_eo = 0;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_own[i] = 0; m_obj[i] = 0; m_pin[i] = 0; end
            lru.delete();
            m_walk = -1;
            e_tag = "R1";
        end else if (m_walk >= 0) begin
            e_tag = "R11";
            e_pv = 1; e_ps = m_walk;
            if (m_own[m_walk]) begin e_pe = 1; e_po = m_obj[m_walk]; lru_touch(m_walk); end
            if (m_walk == NS - 1) begin e_rv = 1; m_walk = -1; end
            else m_walk++;
        end else if (cmd_valid && cmd_op >= 1 && cmd_op <= 5) begin
            h = find_obj(int'(cmd_obj));
            fs = int'(first_slot);
            e_rv = 1;
            case (cmd_op)
                3'd1: begin
                    if (h >= 0) begin
                        e_sl = h; e_fe = 1;
                        if (!cmd_dirty) begin e_tag = "R5"; lru_touch(h); end
                        else if (cmd_tiled) begin
                            e_tag = "R6"; lru_touch(h);
                            e_pv = 1; e_pe = 1; e_ps = h; e_po = cmd_obj;
                        end else begin
                            e_tag = "R6"; lru_del(h); m_own[h] = 0; e_fe = 0;
                            e_pv = 1; e_ps = h;
                        end
                    end else if (!cmd_tiled) begin
                        e_tag = "R7";
                    end else begin
                        f = -1; v = -1;
                        for (int i = fs; i < NS; i++) if (!m_own[i]) begin f = i; break; end
                        if (f < 0)
                            for (int k = 0; k < lru.size(); k++)
                                if (lru[k] >= fs && m_pin[lru[k]] == 0) begin v = lru[k]; break; end
                        if (f < 0 && v < 0) begin
                            e_tag = "R4"; e_st = flip_pending ? 1 : 2;
                        end else begin
                            if (f >= 0) e_tag = "R2";
                            else begin e_tag = "R3"; f = v; e_ev = 1; e_eo = m_obj[v]; end
                            m_own[f] = 1; m_obj[f] = cmd_obj; m_pin[f] = 0; lru_touch(f);
                            e_sl = f; e_fe = 1; e_pv = 1; e_pe = 1; e_ps = f; e_po = cmd_obj;
                        end
                    end
                end
                3'd2: begin
                    e_tag = "R8";
                    if (h >= 0) begin
                        e_sl = h;
                        if (m_pin[h] != 0) begin e_st = 3; e_fe = 1; end
                        else begin m_own[h] = 0; lru_del(h); e_pv = 1; e_ps = h; end
                    end
                end
                3'd3: begin
                    e_tag = "R9";
                    if (h >= 0) begin
                        e_sl = h; e_fe = 1;
                        if (m_pin[h] == PMAX) e_st = 4; else m_pin[h]++;
                    end
                end
                3'd4: begin
                    e_tag = "R10";
                    if (h >= 0) begin
                        e_sl = h; e_fe = 1;
                        if (m_pin[h] == 0) e_st = 4; else m_pin[h]--;
                    end
                end
                default: begin e_tag = "R11"; e_rv = 0; m_walk = 0; end
            endcase
        end else begin
            e_tag = "R12";
        end
        e_rdy = (m_walk < 0) ? 1 : 0;
    end

    // compare all outputs away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk(e_tag, "ready", int'(ready), e_rdy);
            chk(e_tag, "rsp_valid", int'(rsp_valid), e_rv);
            if (rsp_valid && e_rv == 1) begin
                chk(e_tag, "rsp_status", int'(rsp_status), e_st);
                chk(e_tag, "rsp_fence", int'(rsp_fence), e_fe);
                if (e_fe == 1) chk(e_tag, "rsp_slot", int'(rsp_slot), e_sl);
            end
            chk(e_tag, "evict_valid", int'(evict_valid), e_ev);
            if (evict_valid && e_ev == 1) chk(e_tag, "evict_obj", int'(evict_obj), e_eo);
            chk(e_tag, "prog_valid", int'(prog_valid), e_pv);
            if (prog_valid && e_pv == 1) begin
                chk(e_tag, "prog_slot", int'(prog_slot), e_ps);
                chk(e_tag, "prog_enable", int'(prog_enable), e_pe);
                if (e_pe == 1) chk(e_tag, "prog_obj", int'(prog_obj), e_po);
            end
        end
    end

    // drive one command for one cycle (called at a falling edge)
    task automatic cmd(int op, int obj, bit tiled, bit dirty);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_obj = OW'(obj);
        cmd_tiled = tiled; cmd_dirty = dirty;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                        // R1 checked during reset cycles
        for (int i = 0; i < NS; i++) cmd(1, 10 + i, 1, 0);   // R2 fill
        cmd(1, 11, 1, 0);                    // R5 clean re-get
        cmd(1, 30, 1, 0);                    // R3 steal slot 0
        cmd(3, 12, 1, 0); cmd(3, 13, 1, 0);
        cmd(1, 31, 1, 0);                    // R3 skip pinned slots
        cmd(3, 15, 1, 0); cmd(3, 16, 1, 0); cmd(3, 17, 1, 0);
        cmd(3, 11, 1, 0); cmd(3, 30, 1, 0); cmd(3, 31, 1, 0);
        flip_pending = 1'b0; cmd(1, 40, 1, 0); // R4 deadlock
        flip_pending = 1'b1; cmd(1, 40, 1, 0); // R4 again
        flip_pending = 1'b0;
        cmd(2, 12, 1, 0);                    // R8 busy
        cmd(4, 12, 1, 0); cmd(4, 12, 1, 0);  // R10 underflow
        cmd(2, 12, 1, 0); cmd(2, 99, 1, 0);  // R8 free, no-op
        cmd(1, 41, 0, 0);                    // R7
        cmd(1, 41, 1, 0);                    // R2 reuse slot 2
        cmd(1, 15, 1, 1);                    // R6 reprogram
        cmd(1, 16, 0, 1);                    // R6 disable
        cmd(3, 17, 1, 0); cmd(3, 17, 1, 0); cmd(3, 17, 1, 0); // R9 saturate
        cmd(3, 99, 1, 0);                    // R9 no fence
        cmd(0, 5, 1, 0); cmd(7, 5, 1, 0);    // R12 unused ops
        cmd(5, 0, 0, 0);                     // R11 restore
        cmd(1, 77, 1, 0);                    // R12 ignored while busy
        idle(NS + 1);
        cmd(2, 41, 1, 0);
        first_slot = SW'(3);
        cmd(1, 50, 1, 0);                    // R2 search starts at 3
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 29);
            cmd_valid = ($urandom_range(0, 3) != 0);
            cmd_op = (r == 0) ? 3'd5 : (r < 14) ? 3'd1 : (r < 19) ? 3'd2 :
                     (r < 25) ? 3'd3 : (r < 29) ? 3'd4 : 3'd6;
            cmd_obj = OW'(20 + $urandom_range(0, 11));
            cmd_tiled = ($urandom_range(0, 3) != 0);
            cmd_dirty = ($urandom_range(0, 4) == 0);
            flip_pending = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 40) == 0) first_slot = SW'($urandom_range(0, 3));
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        idle(NS + 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule